// File: doc/BRIEF.md
# E1 National Bit Overhead Inserter

This block supplies the values of the national bits Sa4 to Sa8 for an outgoing E1 frame stream. The transmit framer announces each upcoming bit position with a one-cycle strobe. The strobe carries the frame parity, the timeslot number and the bit index. For every announced national bit position, the block returns the bit to transmit as a one-cycle pulse. The pulse arrives exactly one bit time after the strobe, which is when the announced bit begins to go out.

A two-bit source select picks where the national bits come from. The choices are the serial transmit data, a data-link controller, or an external overhead port. A five-bit mask picks which of Sa4 to Sa8 carry data-link bits. The other positions keep the serial data. A new select value is adopted only at the first bit of the next frame-alignment frame, so one double-frame never mixes sources.

For the overhead port, the block drives a strobe clock to the far end. Each enabled national bit gets one pulse, high for the first half of the bit time. The far end launches its bit on the rising edge, and the block captures it on the falling edge.

The control is a four-state machine:
- `ST_IDLE` waits for a strobe that announces a national position.
- `ST_PASS` holds a serial or data-link bit for one bit time.
- `ST_OH_HI` drives the overhead clock high.
- `ST_OH_LO` holds the captured overhead bit for the second half of the bit time.

The transitions are:
- idle to pass, or idle to overhead-high, on a national strobe;
- overhead-high to overhead-low when the half-period count expires;
- pass or overhead-low back to idle when the bit time ends;
- pass or overhead-low straight into a new window when the end of the bit time coincides with the next national strobe.

Top module: `e1_natbit_inserter`

## Requirements
- R1: After reset, `ohp_clk` and `ins_valid` are 0, and the active source is the serial input, whatever `src_sel` holds, until the first frame-alignment boundary.
- R2: A national position is a strobe with `frm_odd`=1, `ts_num`=0 and `bit_idx` in 3..7 (index 0 is the MSB, so 3..7 are Sa4..Sa8). Each such strobe yields exactly one `ins_valid` pulse, BIT_CLKS cycles after the strobe edge. No other strobe yields a pulse.
- R3: With active select 00 or 11, `ins_bit` equals `ser_bit` as sampled on the strobe cycle.
- R4: With active select 01 and the position enabled, `ins_bit` equals `dl_bit` as sampled on the strobe cycle.
- R5: With active select 10 and the position enabled, `ins_bit` equals `ohp_din` as sampled on the clock edge where `ohp_clk` falls.
- R6: `ohp_clk` pulses once for each enabled national position under select 10, and never otherwise. The pulse goes high on the edge after the strobe and stays high for BIT_CLKS/2 cycles.
- R7: Mask bit k (bit 0 = Sa4 ... bit 4 = Sa8) at 0 makes that position take `ser_bit` under select 01 or 10, with no `ohp_clk` pulse.
- R8: A change of `src_sel` becomes active only at a strobe with `frm_odd`=0, `ts_num`=0 and `bit_idx`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pos_stb | input | 1 | One-cycle strobe announcing the next bit position, period BIT_CLKS |
| frm_odd | input | 1 | 1 = non-frame-alignment frame |
| ts_num | input | 5 | Timeslot of the announced bit |
| bit_idx | input | 3 | Bit index within the timeslot, 0 = MSB |
| src_sel | input | 2 | Source select: 00/11 serial, 01 data link, 10 overhead port |
| sa_mask | input | 5 | Data-link enable per national bit, bit 0 = Sa4 |
| ser_bit | input | 1 | Serial transmit data bit for the announced position |
| dl_bit | input | 1 | Data-link controller bit for the announced position |
| ohp_din | input | 1 | External overhead data |
| ohp_clk | output | 1 | Overhead strobe clock to the external device |
| ins_valid | output | 1 | One-cycle pulse: national bit value ready |
| ins_bit | output | 1 | National bit value to transmit |

## Verification
The hardest case to reach is a select change that arrives after a frame-alignment boundary, while the following odd frame is still being transmitted. The block must keep the old source for that whole frame. The bench writes a new `src_sel` between a frame-alignment frame and its odd frame, then sends a second odd frame before the next boundary. Every national result in both frames must still follow the old source.

The far-end model inverts `ohp_din` as soon as `ohp_clk` falls. A capture taken one edge late would therefore return the wrong bit.

// File: rtl/nb_pkg.sv
package nb_pkg;

    typedef enum logic [1:0] {
        SRC_SER = 2'd0,
        SRC_DL  = 2'd1,
        SRC_OH  = 2'd2
    } nb_src_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PASS  = 2'd1,
        ST_OH_HI = 2'd2,
        ST_OH_LO = 2'd3
    } nb_state_e;

    // Map the two-bit select field onto a source; 11 folds onto serial.
    function automatic nb_src_e sel_to_src(input logic [1:0] sel);
        unique case (sel)
            2'b01:   return SRC_DL;
            2'b10:   return SRC_OH;
            default: return SRC_SER;
        endcase
    endfunction

endpackage

// File: rtl/nb_slot_decode.sv
module nb_slot_decode #(
    parameter int TS_W     = 5,
    parameter int IDX_W    = 3,
    parameter int SA_N     = 5,
    parameter int SA_FIRST = 3
) (
    input  logic             frm_odd,
    input  logic [TS_W-1:0]  ts_num,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic [SA_N-1:0]  sa_mask,
    output logic             is_nat,
    output logic             sa_en,
    output logic             fas_start
);
    localparam int SA_LAST = SA_FIRST + SA_N - 1;

    logic [SA_N-1:0] hit;

    for (genvar k = 0; k < SA_N; k++) begin : g_sa
        assign hit[k] = (bit_idx == IDX_W'(SA_FIRST + k)) && sa_mask[k];
    end

    always_comb begin
        is_nat    = frm_odd && (ts_num == '0)
                    && (bit_idx >= IDX_W'(SA_FIRST))
                    && (bit_idx <= IDX_W'(SA_LAST));
        sa_en     = is_nat && (|hit);
        fas_start = !frm_odd && (ts_num == '0) && (bit_idx == '0);
    end
endmodule

// File: rtl/nb_sel_hold.sv
module nb_sel_hold
    import nb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pos_stb,
    input  logic       fas_start,
    input  logic [1:0] src_sel,
    output nb_src_e    act_src
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_src <= SRC_SER;
        end else if (pos_stb && fas_start) begin
            act_src <= sel_to_src(src_sel);
        end
    end

    // R8: the active source moves only at a frame-alignment boundary strobe
    p_sel_at_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_src) |-> $past(pos_stb && fas_start));
endmodule

// File: rtl/nb_src_pick.sv
module nb_src_pick
    import nb_pkg::*;
(
    input  nb_src_e act_src,
    input  logic    sa_en,
    input  logic    ser_bit,
    input  logic    dl_bit,
    output logic    uses_oh,
    output logic    direct_bit
);
    always_comb begin
        uses_oh    = 1'b0;
        direct_bit = ser_bit;
        if (sa_en) begin
            unique case (act_src)
                SRC_DL:  direct_bit = dl_bit;
                SRC_OH:  uses_oh    = 1'b1;
                default: direct_bit = ser_bit;
            endcase
        end
    end
endmodule

// File: rtl/e1_natbit_inserter.sv
module e1_natbit_inserter
    import nb_pkg::*;
#(
    parameter int BIT_CLKS = 8,
    parameter int TS_W     = 5,
    parameter int IDX_W    = 3,
    parameter int SA_N     = 5,
    parameter int SA_FIRST = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pos_stb,
    input  logic             frm_odd,
    input  logic [TS_W-1:0]  ts_num,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic [1:0]       src_sel,
    input  logic [SA_N-1:0]  sa_mask,
    input  logic             ser_bit,
    input  logic             dl_bit,
    input  logic             ohp_din,
    output logic             ohp_clk,
    output logic             ins_valid,
    output logic             ins_bit
);
    localparam int HALF = BIT_CLKS / 2;
    localparam int CW   = $clog2(BIT_CLKS);

    nb_state_e state, state_nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic          hold_bit;
    logic          is_nat, sa_en, fas_start;
    logic          uses_oh, direct_bit;
    nb_src_e       act_src;
    logic          start_ok, done;

    nb_slot_decode #(
        .TS_W(TS_W), .IDX_W(IDX_W), .SA_N(SA_N), .SA_FIRST(SA_FIRST)
    ) u_dec (
        .frm_odd(frm_odd), .ts_num(ts_num), .bit_idx(bit_idx),
        .sa_mask(sa_mask), .is_nat(is_nat), .sa_en(sa_en),
        .fas_start(fas_start)
    );

    nb_sel_hold u_sel (
        .clk(clk), .rst_n(rst_n), .pos_stb(pos_stb),
        .fas_start(fas_start), .src_sel(src_sel), .act_src(act_src)
    );

    nb_src_pick u_pick (
        .act_src(act_src), .sa_en(sa_en), .ser_bit(ser_bit),
        .dl_bit(dl_bit), .uses_oh(uses_oh), .direct_bit(direct_bit)
    );

    assign start_ok = pos_stb && is_nat;

    // Next state and counter
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        done      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start_ok) begin
                    state_nxt = uses_oh ? ST_OH_HI : ST_PASS;
                    cnt_nxt   = uses_oh ? CW'(HALF - 1) : CW'(BIT_CLKS - 1);
                end
            end
            ST_OH_HI: begin
                if (cnt == '0) begin
                    state_nxt = ST_OH_LO;
                    cnt_nxt   = CW'(HALF - 1);
                end else begin
                    cnt_nxt = cnt - 1'b1;
                end
            end
            ST_PASS, ST_OH_LO: begin
                if (cnt == '0) begin
                    done = 1'b1;
                    if (start_ok) begin
                        state_nxt = uses_oh ? ST_OH_HI : ST_PASS;
                        cnt_nxt   = uses_oh ? CW'(HALF - 1) : CW'(BIT_CLKS - 1);
                    end else begin
                        state_nxt = ST_IDLE;
                    end
                end else begin
                    cnt_nxt = cnt - 1'b1;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // State register, counter and held bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            hold_bit <= 1'b0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
            if (start_ok && (state == ST_IDLE || done)) begin
                hold_bit <= direct_bit;
            end else if (state == ST_OH_HI && cnt == '0) begin
                hold_bit <= ohp_din;
            end
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ohp_clk   <= 1'b0;
            ins_valid <= 1'b0;
            ins_bit   <= 1'b0;
        end else begin
            ohp_clk   <= (state_nxt == ST_OH_HI);
            ins_valid <= done;
            if (done) begin
                ins_bit <= hold_bit;
            end
        end
    end

    // R6: a rising overhead clock follows an overhead-sourced national strobe
    p_clk_rise_on_oh_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ohp_clk) |-> $past(start_ok && uses_oh));

    // R6: the clock falls only on entry to the low half of a window
    p_clk_fall_into_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ohp_clk) |-> (state == ST_OH_LO));

    // R2: a result pulse only closes an open window
    p_valid_from_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |-> $past(state == ST_PASS || state == ST_OH_LO));

    // R2: strobes in frame-alignment frames never start an overhead pulse
    p_no_clk_in_fas_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_stb && !frm_odd) |=> !$rose(ohp_clk));
endmodule

// File: tb/e1_natbit_inserter_tb.sv
module e1_natbit_inserter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CLKS   = 8;
    localparam int HALF       = BIT_CLKS / 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic pos_stb = 1'b0, frm_odd = 1'b0;
    logic [4:0] ts_num = '0;
    logic [2:0] bit_idx = '0;
    logic [1:0] src_sel = 2'b00;
    logic [4:0] sa_mask = '0;
    logic ser_bit = 1'b0, dl_bit = 1'b0, ohp_din = 1'b0;
    logic ohp_clk, ins_valid, ins_bit;

    typedef struct {
        logic  val;
        int    due;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    logic oh_q[$];
    int   checks = 0, errors = 0, cyc = 0;
    int   exp_pulses = 0, seen_pulses = 0;
    logic [1:0] m_sel = 2'b00;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc++;

    e1_natbit_inserter #(.BIT_CLKS(BIT_CLKS)) u_dut (
        .clk(clk), .rst_n(rst_n), .pos_stb(pos_stb), .frm_odd(frm_odd),
        .ts_num(ts_num), .bit_idx(bit_idx), .src_sel(src_sel),
        .sa_mask(sa_mask), .ser_bit(ser_bit), .dl_bit(dl_bit),
        .ohp_din(ohp_din), .ohp_clk(ohp_clk), .ins_valid(ins_valid),
        .ins_bit(ins_bit)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Far-end device: launch on rising edge, scramble right after falling edge
    initial forever begin
        @(posedge ohp_clk);
        seen_pulses++;
        if (oh_q.size() == 0) begin
            check(0, "R6 unexpected pulse", 1, 0);
        end else begin
            ohp_din = oh_q.pop_front();
        end
        @(negedge ohp_clk);
        ohp_din = ~ohp_din;
    end

    // Driver: one bit position, one strobe, BIT_CLKS cycles; pushes expectations
    task automatic send_bit(input logic odd, input int ts, input int idx);
        logic s, d, o, en, nat;
        exp_t e;
        s = 1'($urandom); d = 1'($urandom); o = 1'($urandom);
        frm_odd = odd; ts_num = 5'(ts); bit_idx = 3'(idx);
        ser_bit = s; dl_bit = d; pos_stb = 1'b1;
        nat = odd && ts == 0 && idx >= 3;
        if (!odd && ts == 0 && idx == 0) m_sel = src_sel;   // R8 boundary
        if (nat) begin
            en = sa_mask[idx-3];
            e.due = cyc + 1 + BIT_CLKS;
            if (!en) begin
                e.val = s; e.tag = (m_sel == 2'b01 || m_sel == 2'b10) ? "R7" : "R3";
            end else if (m_sel == 2'b01) begin
                e.val = d; e.tag = "R4";
            end else if (m_sel == 2'b10) begin
                e.val = o; e.tag = "R5"; oh_q.push_back(o); exp_pulses++;
            end else begin
                e.val = s; e.tag = "R3";
            end
            exp_q.push_back(e);
        end
        @(negedge clk);
        pos_stb = 1'b0; ser_bit = ~s; dl_bit = ~d;
        repeat (BIT_CLKS-1) @(negedge clk);
    endtask

    task automatic send_frame(input logic odd);
        for (int t = 0; t < 32; t++)
            for (int i = 0; i < 8; i++)
                send_bit(odd, t, i);
    endtask

    // Monitor: pop and compare result pulses; check overhead clock width
    int hi_run = 0;
    initial forever begin
        @(negedge clk);
        if (rst_n && ins_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "R2 pulse at non-national position", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(ins_bit == e.val, e.tag, int'(ins_bit), int'(e.val));
                check(cyc == e.due, "R2 result timing", cyc, e.due);
            end
        end
        if (ohp_clk) hi_run++;
        else if (hi_run != 0) begin
            check(hi_run == HALF, "R6 high width", hi_run, HALF);
            hi_run = 0;
        end
    end

    initial begin
        #(CLK_PERIOD * 190000);
        check(0, "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(ohp_clk == 1'b0, "R1 ohp_clk in reset", int'(ohp_clk), 0);
        check(ins_valid == 1'b0, "R1 ins_valid in reset", int'(ins_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1/R8: select written but no boundary yet -> serial source
        src_sel = 2'b10; sa_mask = 5'h1F;
        send_frame(1'b1);
        // boundary adopts overhead port, R5 and R6
        send_frame(1'b0); send_frame(1'b1);
        // R7 with overhead port, partial mask
        sa_mask = 5'b01010; send_frame(1'b1);
        // R4 and R7 with data link
        src_sel = 2'b01; sa_mask = 5'b10101;
        send_frame(1'b0); send_frame(1'b1);
        // R8: change after boundary stays inactive across two odd frames
        src_sel = 2'b10; sa_mask = 5'h1F;
        send_frame(1'b1); send_frame(1'b1);
        // R3: select 11 and 00 both take serial data
        src_sel = 2'b11; send_frame(1'b0); send_frame(1'b1);
        src_sel = 2'b00; send_frame(1'b0); send_frame(1'b1);
        repeat (2*BIT_CLKS) @(negedge clk);
        check(exp_q.size() == 0, "R2 missing results", exp_q.size(), 0);
        check(seen_pulses == exp_pulses, "R6 pulse count", seen_pulses, exp_pulses);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule